// File: doc/BRIEF.md
# Long/Short Frame PCM Serial Port

This block is a full-duplex serial port for one 8-bit voice channel. It runs in the system clock domain and takes the transmit and receive bit clocks and frame syncs as plain inputs that it oversamples. The two directions have independent bit clocks and syncs. Once per frame the transmit side takes one byte from a valid/ready stream and shifts it out MSB first. It drives a data pin together with an output-enable flag that a pad tri-state uses. The receive side shifts one byte in per frame and presents it with a one-cycle valid pulse.

The port measures each sync pulse by counting the bit-clock falling edges that see it high. It then times the next frame as long-sync or short-sync from that count. After reset and after every power-down, the transmit side stays silent for a set number of frames, so that two talkers cannot collide on a shared line.

Back-pressure rules: `tx_ready` is high while the one-word holding register is empty. A byte moves when `tx_valid` and `tx_ready` are both high on a clock edge. `tx_data` is ignored at other times. The receive stream has no ready input. `rx_valid` lasts exactly one clock, and the sink must take `rx_data` in that cycle.

Top module: `pcm_frame_port`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any cycle in which `pwr_up` is low, `tx_oe` and `rx_valid` are low and `tx_ready` is high. A byte that was held and not yet sent is dropped.
- R2: Counting from the release of reset or the return of `pwr_up`, the first two transmit frame starts (sync rising edges) are not transmitted and `tx_oe` stays low through them. Transmission resumes with the third frame.
- R3: A sync pulse that is high on two or more consecutive bit-clock falling edges is classed long. A pulse that is high on exactly one falling edge is classed short. The class of the last completed pulse sets the timing of the next frame.
- R4: In a short frame, `tx_oe` rises and D7 is driven at the first bit-clock rising edge after the falling edge that saw sync high. Bits then follow MSB first, one per rising edge, so the receiver's falling edges 1 to 8 see D7 to D0. `tx_oe` falls at the eighth falling edge.
- R5: In a long frame, `tx_oe` rises and D7 is driven as soon as sync rises. The following bits change on rising edges, so falling edges 1 to 8 after the sync rise see D7 to D0. `tx_oe` falls at whichever comes later: the eighth falling edge, or sync going low.
- R6: In a short frame, the receiver samples `rx_pin` on the eight bit-clock falling edges that follow the edge that saw sync high. The first sample goes to bit 7. After the eighth sample it raises `rx_valid` for exactly one clock, with the byte on `rx_data`.
- R7: In a long frame, the receiver samples `rx_pin` on the first eight bit-clock falling edges after sync rises, again MSB first, and gives one `rx_valid` pulse per frame.
- R8: `tx_ready` equals "holding register empty". An accepted byte is consumed at the next transmitted frame start. If no byte is held at a frame start, the idle word 0xFF is sent.
- R9: After reset or power-down, no byte is received until a complete sync pulse has been classified. In practice the first frame yields no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | High for operation; low holds the port powered down |
| tx_bclk | input | 1 | Transmit bit clock, oversampled |
| tx_fs | input | 1 | Transmit frame sync |
| tx_data | input | 8 | Stream byte to transmit |
| tx_valid | input | 1 | Stream byte present |
| tx_ready | output | 1 | Holding register empty, byte accepted |
| tx_pin | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Drive enable for the transmit pad |
| rx_bclk | input | 1 | Receive bit clock, oversampled |
| rx_fs | input | 1 | Receive frame sync |
| rx_pin | input | 1 | Serial receive data |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is new |

## Verification
The assertions assume the following about the inputs:
- The bit clocks and syncs are synchronous to `clk` and keep each level for at least two clock cycles.
- Sync never changes in the same clock cycle as the bit clock.
- `pwr_up` changes only between frames.

The stimulus builds every bit period from eight system clocks. It moves sync only in the middle of a bit-clock phase and toggles power only while the bus is idle. When the sync width switches between short and long, the next frame is deliberately misaligned by design. The stimulus sends such transition frames but checks none of their data; it only keeps track of the byte they consume.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    FK_SHORT = 1'b0,
    FK_LONG  = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/pcm_sync_class.sv
// Oversamples one bit clock / sync pair and classes each sync pulse
// by the number of bit-clock falling edges that saw it high.
module pcm_sync_class
  import pcm_port_pkg::*;
#(
  parameter int LONG_MIN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        bclk,
  input  logic        fs,
  output logic        bclk_fall,
  output logic        fs_rise,
  output logic        fs_first,
  output frame_kind_e kind,
  output logic        kind_ok
);
  localparam int CW = $clog2(LONG_MIN + 1);

  logic          bclk_q;
  logic          fs_q;
  logic [CW-1:0] hi_cnt;

  assign bclk_fall = ~bclk & bclk_q;
  assign fs_rise   = fs & ~fs_q;
  assign fs_first  = bclk_fall & fs & (hi_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fs_q    <= 1'b0;
      hi_cnt  <= '0;
      kind    <= FK_SHORT;
      kind_ok <= 1'b0;
    end else begin
      bclk_q <= bclk;
      fs_q   <= fs;
      if (clr) begin
        hi_cnt  <= '0;
        kind    <= FK_SHORT;
        kind_ok <= 1'b0;
      end else if (bclk_fall) begin
        if (fs) begin
          if (hi_cnt != CW'(LONG_MIN)) hi_cnt <= hi_cnt + 1'b1;
        end else if (hi_cnt != '0) begin
          kind    <= (hi_cnt == CW'(LONG_MIN)) ? FK_LONG : FK_SHORT;
          kind_ok <= 1'b1;
          hi_cnt  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
// Transmit side: one-word holding register, quiet-frame gate,
// MSB-first shifter and output-enable window.
module pcm_tx_shift
  import pcm_port_pkg::*;
#(
  parameter int           W     = 8,
  parameter logic [W-1:0] IDLE  = '1,
  parameter int           QUIET = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bclk,
  input  logic         bclk_fall,
  input  logic         fs,
  input  logic         fs_rise,
  input  logic         fs_first,
  input  frame_kind_e  kind,
  input  logic         kind_ok,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         pin,
  output logic         oe
);
  localparam int QW = $clog2(QUIET + 1);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  hold, sh;
  logic          full, frame_ok, armed, active, cur_long, bclk_q;
  logic [QW-1:0] qcnt;
  logic [CW-1:0] fcnt;
  logic          bclk_rise, quiet_done, start_long, start_short, word_done;

  assign bclk_rise   = bclk & ~bclk_q;
  assign quiet_done  = (qcnt == QW'(QUIET));
  assign start_long  = fs_rise & quiet_done & kind_ok & (kind == FK_LONG);
  assign start_short = fs_first & frame_ok & kind_ok & (kind == FK_SHORT);
  assign word_done   = (fcnt == CW'(W));
  assign oe          = active & (~word_done | (cur_long & fs));
  assign in_ready    = ~full;
  assign pin         = sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; sh <= '0; full <= 1'b0; frame_ok <= 1'b0;
      armed <= 1'b0; active <= 1'b0; cur_long <= 1'b0;
      qcnt <= '0; fcnt <= '0;
    end else if (clr) begin
      hold <= '0; sh <= '0; full <= 1'b0; frame_ok <= 1'b0;
      armed <= 1'b0; active <= 1'b0; cur_long <= 1'b0;
      qcnt <= '0; fcnt <= '0;
    end else begin
      if (in_valid && !full) begin
        hold <= in_data;
        full <= 1'b1;
      end
      if (fs_rise) begin
        if (!quiet_done) qcnt <= qcnt + 1'b1;
        frame_ok <= quiet_done;
      end
      if (start_long || start_short) begin
        sh <= full ? hold : IDLE;
        if (full) full <= 1'b0;
      end
      if (start_long) begin
        active   <= 1'b1;
        cur_long <= 1'b1;
        fcnt     <= '0;
        armed    <= 1'b0;
      end else if (start_short) begin
        armed <= 1'b1;
      end else if (armed && bclk_rise) begin
        active   <= 1'b1;
        cur_long <= 1'b0;
        fcnt     <= '0;
        armed    <= 1'b0;
      end else if (active) begin
        if (bclk_fall && !word_done) fcnt <= fcnt + 1'b1;
        if (bclk_rise && fcnt != '0 && !word_done) sh <= {sh[W-2:0], 1'b0};
        if (word_done && !(cur_long && fs)) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_shift.sv
// Receive side: falling-edge sampler, MSB first, one valid pulse per word.
module pcm_rx_shift
  import pcm_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bclk_fall,
  input  logic         fs_rise,
  input  logic         fs_first,
  input  frame_kind_e  kind,
  input  logic         kind_ok,
  input  logic         pin,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh;
  logic [CW-1:0] fcnt;
  logic          active, start;

  assign start = kind_ok & ((fs_rise & (kind == FK_LONG)) |
                            (fs_first & (kind == FK_SHORT)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; fcnt <= '0; active <= 1'b0;
      out_data <= '0; out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (clr) begin
        sh <= '0; fcnt <= '0; active <= 1'b0; out_data <= '0;
      end else if (start) begin
        active <= 1'b1;
        fcnt   <= '0;
      end else if (active && bclk_fall) begin
        sh <= {sh[W-2:0], pin};
        if (fcnt == CW'(W - 1)) begin
          out_data  <= {sh[W-2:0], pin};
          out_valid <= 1'b1;
          active    <= 1'b0;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
  import pcm_port_pkg::*;
#(
  parameter int                WORD_W         = 8,
  parameter logic [WORD_W-1:0] IDLE_WORD      = '1,
  parameter int                QUIET_FRAMES   = 2,
  parameter int                LONG_MIN_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_up,
  input  logic              tx_bclk,
  input  logic              tx_fs,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_pin,
  output logic              tx_oe,
  input  logic              rx_bclk,
  input  logic              rx_fs,
  input  logic              rx_pin,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  logic        clr;
  logic        t_fall, t_rise_fs, t_first, t_ok;
  logic        r_fall, r_rise_fs, r_first, r_ok;
  frame_kind_e t_kind, r_kind;

  assign clr = ~pwr_up;

  pcm_sync_class #(.LONG_MIN(LONG_MIN_EDGES)) u_tx_class (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bclk(tx_bclk), .fs(tx_fs),
    .bclk_fall(t_fall), .fs_rise(t_rise_fs), .fs_first(t_first),
    .kind(t_kind), .kind_ok(t_ok)
  );

  pcm_sync_class #(.LONG_MIN(LONG_MIN_EDGES)) u_rx_class (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bclk(rx_bclk), .fs(rx_fs),
    .bclk_fall(r_fall), .fs_rise(r_rise_fs), .fs_first(r_first),
    .kind(r_kind), .kind_ok(r_ok)
  );

  pcm_tx_shift #(.W(WORD_W), .IDLE(IDLE_WORD), .QUIET(QUIET_FRAMES)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bclk(tx_bclk), .bclk_fall(t_fall),
    .fs(tx_fs), .fs_rise(t_rise_fs), .fs_first(t_first), .kind(t_kind),
    .kind_ok(t_ok), .in_data(tx_data), .in_valid(tx_valid),
    .in_ready(tx_ready), .pin(tx_pin), .oe(tx_oe)
  );

  pcm_rx_shift #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bclk_fall(r_fall),
    .fs_rise(r_rise_fs), .fs_first(r_first), .kind(r_kind), .kind_ok(r_ok),
    .pin(rx_pin), .out_data(rx_data), .out_valid(rx_valid)
  );
endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk #(
  parameter int QUIET = 2
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_up,
  input logic tx_fs,
  input logic tx_bclk,
  input logic tx_oe,
  input logic tx_pin,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid
);
  logic       fs_d;
  logic [7:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_d  <= 1'b0;
      rises <= '0;
    end else begin
      fs_d <= tx_fs;
      if (!pwr_up) rises <= '0;
      else if (tx_fs && !fs_d && rises <= 8'(QUIET)) rises <= rises + 1'b1;
    end
  end

  // R1: power-down silences both directions
  p_powerdown_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> (!tx_oe && !rx_valid));

  // R2: no drive until more than QUIET frame starts have been seen
  p_quiet_frames_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> (rises > 8'(QUIET)));

  // R4: while driven, the data changes only after a bit-clock rising edge
  p_pin_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe && $past(tx_oe) && (tx_pin != $past(tx_pin)))
      |-> ($past(tx_bclk) && !$past(tx_bclk, 2)));

  // R6: the receive strobe is a single cycle
  p_rx_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8: an accepted byte fills the holding register
  p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up && tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind pcm_frame_port pcm_frame_port_chk #(.QUIET(QUIET_FRAMES)) chk_i (.*);

// File: tb/pcm_frame_port_tb_top.sv
`timescale 1ns/1ps
module pcm_frame_port_tb_top;
  localparam int CLK_P = 10;
  localparam int NSLOT = 32;

  logic       clk = 1'b0, rst_n = 1'b0, pwr_up = 1'b1;
  logic       bclk = 1'b0, fs = 1'b0, tx_valid = 1'b0, rx_pin = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, tx_pin, tx_oe, rx_valid;
  logic [7:0] rx_data;

  int         total = 0, bad = 0, rx_seen = 0;
  logic [7:0] rx_last = 8'h00;
  bit         q_has = 0;
  logic [7:0] q_byte = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  pcm_frame_port dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up),
    .tx_bclk(bclk), .tx_fs(fs), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_pin(tx_pin), .tx_oe(tx_oe),
    .rx_bclk(bclk), .rx_fs(fs), .rx_pin(rx_pin),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_seen = rx_seen + 1;
      rx_last = rx_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] next_tx_word();
    logic [7:0] w;
    w = q_has ? q_byte : 8'hFF;
    q_has = 0;
    return w;
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    q_has  = 1;
    q_byte = b;
  endtask

  // One frame of NSLOT bit periods, 8 clocks each.
  // lng/hi: sync shape; tx_on: transmit expected; chk: check this frame;
  // rx_on: one received word expected.
  task automatic run_frame(input bit lng, input int hi, input bit tx_on,
                           input bit chk, input bit rx_on, input logic [7:0] rx_byte);
    logic [7:0] got;
    logic [7:0] want;
    int         seen0;
    string      tg;
    got   = 8'h00;
    seen0 = rx_seen;
    want  = tx_on ? next_tx_word() : 8'h00;
    tg    = !tx_on ? "R2" : (lng ? "R3 R5" : "R4");
    for (int s = 0; s < NSLOT; s++) begin
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        if (chk) begin
          if (s == 0 && p == 7)
            check(tx_oe == (lng && tx_on), tg, tx_oe, lng && tx_on);
          if (s == 1 && p == 1)
            check(tx_oe == tx_on, tg, tx_oe, tx_on);
          if (p == 4 && s >= 1 && s <= 8) begin
            if (tx_oe != tx_on) check(0, tg, tx_oe, tx_on);
            got[8-s] = tx_pin;
          end
          if (p == 4 && s == 9)
            check(tx_oe == (tx_on && lng && hi >= 9), tg, tx_oe, tx_on && lng && hi >= 9);
          if (p == 7 && lng && hi >= 9 && s == hi)
            check(tx_oe == 1'b0, "R5", tx_oe, 0);
          if (p == 4 && s == 12)
            check(tx_oe == 1'b0, tg, tx_oe, 0);
        end
        if (p == 0) begin
          bclk = 1'b1;
          if (s >= 1 && s <= 8) rx_pin = rx_byte[8-s];
        end
        if (p == 4) bclk = 1'b0;
        if (!lng) begin
          if (s == 0 && p == 1) fs = 1'b1;
          if (s == 0 && p == 6) fs = 1'b0;
        end else begin
          if (s == 0 && p == 6) fs = 1'b1;
          if (s == hi && p == 6) fs = 1'b0;
        end
      end
    end
    if (chk) begin
      if (tx_on) check(got == want, tg, got, want);
      if (rx_on) begin
        check(rx_seen - seen0 == 1, lng ? "R7" : "R6", rx_seen - seen0, 1);
        check(rx_last == rx_byte, lng ? "R7" : "R6", rx_last, rx_byte);
      end else begin
        check(rx_seen - seen0 == 0, "R9", rx_seen - seen0, 0);
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    rb = 8'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    check(tx_oe == 1'b0, "R1", tx_oe, 0);
    check(tx_ready == 1'b1, "R1", tx_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_valid == 1'b0, "R1", rx_valid, 0);

    // Quiet frames after reset, then short frames
    push(8'hA5);
    check(tx_ready == 1'b0, "R8", tx_ready, 0);
    run_frame(0, 1, 0, 1, 0, 8'h3C);      // R9: nothing received yet
    run_frame(0, 1, 0, 1, 1, 8'hC3);      // R2 quiet, receive active
    run_frame(0, 1, 1, 1, 1, 8'h81);      // first transmitted word
    check(tx_ready == 1'b1, "R8", tx_ready, 1);
    run_frame(0, 1, 1, 1, 1, 8'h00);      // R8: idle word
    // R8 back-pressure: a second byte offered while full is not taken
    push(8'h12);
    @(negedge clk);
    tx_data = 8'hEE; tx_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_ready == 1'b0, "R8", tx_ready, 0);
    tx_valid = 1'b0;
    run_frame(0, 1, 1, 1, 1, 8'h5A);
    for (int i = 0; i < 6; i++) begin
      if ($urandom % 2 == 0) push(8'($urandom));
      rb = 8'($urandom);
      run_frame(0, 1, 1, 1, 1, rb);
    end

    // Switch to long sync: one unchecked transition frame
    run_frame(1, 2, 1, 0, 0, 8'h00);
    for (int i = 0; i < 5; i++) begin
      if ($urandom % 2 == 0) push(8'($urandom));
      rb = 8'($urandom);
      run_frame(1, 2 + int'($urandom % 4), 1, 1, 1, rb);
    end
    push(8'h69);
    run_frame(1, 10, 1, 1, 1, 8'h96);     // sync outlasts the word
    run_frame(1, 11, 1, 1, 1, 8'h0F);

    // Back to short, then power-down
    run_frame(0, 1, 1, 0, 0, 8'h00);
    run_frame(0, 1, 1, 1, 1, 8'hF0);
    push(8'h77);
    pwr_up = 1'b0;
    q_has  = 0;
    repeat (3) @(negedge clk);
    check(tx_oe == 1'b0, "R1", tx_oe, 0);
    check(tx_ready == 1'b1, "R1", tx_ready, 1);
    pwr_up = 1'b1;
    @(negedge clk);
    run_frame(1, 2, 0, 1, 0, 8'h11);      // R9 after power-down
    run_frame(1, 3, 0, 1, 1, 8'h22);      // R2 quiet
    push(8'hC6);
    run_frame(1, 2, 1, 1, 1, 8'h33);
    run_frame(1, 4, 1, 1, 1, 8'hB4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule